// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is a single memory-to-memory copy channel. Software does not write the transfer parameters into registers. It places a four-word descriptor in memory, writes the descriptor's byte address into the channel, and then sets a start bit. The channel reads the descriptor over its memory master port. It then copies the requested number of bytes as 32-bit words, reading each word and writing it back before it moves to the next. When the descriptor asks for it, the channel raises an interrupt at the end of the copy.

The descriptor has four words, stored in this order: a flag word, the source byte address, the destination byte address, and the length in bytes. In the flag word, one bit enables the completion interrupt and two other bits choose whether the source address and the destination address step by one word after each copy. A cleared step flag keeps that address fixed for the whole transfer. This lets the channel fill a buffer from one location, or drain a buffer into one location.

The register window is a plain write-strobe slave with combinational read data. The memory port is a single request/ready master. It holds each request until ready is seen, so the memory may add any number of wait states.

Top module: `dma_cb_channel`

## Requirements
- R1: After reset the control/status register (offset 0x00) reads zero, the descriptor address register (offset 0x04) reads zero, `irq` is low and `mem_req` is low.
- R2: The descriptor address register at offset 0x04 holds the 32-bit value written to it and reads it back.
- R3: Writing a 1 to bit 0 of the control/status register while the channel is idle starts four reads, at the descriptor address plus 0, 4, 8 and 12, in that order. These words are taken as flags, source, destination and byte length.
- R4: After the descriptor, the channel moves length/4 words (any remainder is dropped). Each word is one read from the source followed by one write of the same data to the destination.
- R5: Flag bit 8 makes the source address step by 4 after each word, and flag bit 4 does the same for the destination. With both bits set, word k of the source lands at destination + 4k.
- R6: When a step flag is clear, that address stays the same for every word of the transfer.
- R7: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ready` is high, so any wait-state pattern gives the same result.
- R8: Bit 0 of the control/status register reads 1 from the clock edge after the start write until the last write is accepted, and reads 0 after that. A zero length finishes right after the descriptor fetch and writes nothing.
- R9: When a transfer finishes, bit 2 of the control/status register and `irq` both become 1 if flag bit 0 was set. If flag bit 0 was clear, both stay 0.
- R10: Writing a 1 to bit 2 of the control/status register clears the pending interrupt and drops `irq`. If a completion lands in the same cycle, the completion wins.
- R11: A start write that arrives while the channel is active is ignored: the transfer in progress finishes with exactly its own number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle; read data is valid in the same cycle |
| mem_rdata | input | DATA_W | Memory read data |
| irq | output | 1 | Completion interrupt, level |

## Verification
Several properties are checked on every cycle:
- The request-hold rule of the memory port.
- That `irq` only ever rises right after an interrupt-enabled completion, and that a clear write drops it.
- That a fixed source address never moves during a copy.
- That the port goes quiet after the last accepted write.
- That a start seen during a copy never sends the engine back to the descriptor fetch.

Other behaviour can only be shown by the bench's sweep. It runs every combination of the three flag bits against zero, one, three and eight words, under pseudo-random wait states. That sweep shows the descriptor order, the final memory image for fixed and stepping addresses (including which source word survives at a fixed destination), the exact write count, and the untouched words beyond the destination region.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

    // register window offsets
    localparam int CS_OFS  = 0;
    localparam int CBA_OFS = 4;

    // control/status bits
    localparam int CS_ACTIVE_BIT = 0;
    localparam int CS_INT_BIT    = 2;

    // descriptor flag bits
    localparam int FL_INT_EN_BIT  = 0;
    localparam int FL_DST_INC_BIT = 4;
    localparam int FL_SRC_INC_BIT = 8;

    // descriptor size in words
    localparam int CB_WORDS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic int_en;
        logic dst_inc;
        logic src_inc;
    } xfer_flags_t;

    function automatic xfer_flags_t decode_flags(input logic [31:0] w);
        xfer_flags_t f;
        f.int_en  = w[FL_INT_EN_BIT];
        f.dst_inc = w[FL_DST_INC_BIT];
        f.src_inc = w[FL_SRC_INC_BIT];
        return f;
    endfunction

endpackage

// File: rtl/dma_cb_addr_step.sv
module dma_cb_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] next_o
);
    generate
        if (STEP == 0) begin : g_fixed
            assign next_o = addr_i;
        end else begin : g_step
            assign next_o = inc_i ? (addr_i + ADDR_W'(STEP)) : addr_i;
        end
    endgenerate
endmodule

// File: rtl/dma_cb_regs.sv
module dma_cb_regs
    import dma_cb_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              busy_i,
    input  logic              done_irq_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] cb_base_o,
    output logic              irq_o
);
    logic              cs_sel;
    logic              cba_sel;
    logic              cs_wr;
    logic              int_q;
    logic [ADDR_W-1:0] cba_q;

    assign cs_sel  = (reg_addr_i == REG_AW'(CS_OFS));
    assign cba_sel = (reg_addr_i == REG_AW'(CBA_OFS));
    assign cs_wr   = reg_wen_i && cs_sel;

    // start only from idle
    assign start_o = cs_wr && reg_wdata_i[CS_ACTIVE_BIT] && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q <= 1'b0;
            cba_q <= '0;
        end else begin
            if (reg_wen_i && cba_sel) begin
                cba_q <= reg_wdata_i[ADDR_W-1:0];
            end
            // completion has priority over a clear in the same cycle
            if (done_irq_i) begin
                int_q <= 1'b1;
            end else if (cs_wr && reg_wdata_i[CS_INT_BIT]) begin
                int_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (cs_sel) begin
            reg_rdata_o[CS_ACTIVE_BIT] = busy_i;
            reg_rdata_o[CS_INT_BIT]    = int_q;
        end else if (cba_sel) begin
            reg_rdata_o = DATA_W'(cba_q);
        end
    end

    assign cb_base_o = cba_q;
    assign irq_o     = int_q;

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(done_irq_i)); // R9

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cs_wr && reg_wdata_i[CS_INT_BIT] && !done_irq_i) |=> !irq_o); // R10

endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
    import dma_cb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cb_base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_irq_o
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BSH        = $clog2(WORD_BYTES);
    localparam int FI_W       = $clog2(CB_WORDS);

    eng_state_t        state_q;
    logic [FI_W-1:0]   fidx_q;
    logic [ADDR_W-1:0] cb_q;
    xfer_flags_t       flags_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] left_q;
    logic [DATA_W-1:0] buf_q;

    logic [ADDR_W-1:0] src_next;
    logic [ADDR_W-1:0] dst_next;
    logic [DATA_W-1:0] fetch_words;
    logic              fetch_last;
    logic              copy_last;
    logic              copying;

    dma_cb_addr_step #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_src_step (
        .addr_i (src_q),
        .inc_i  (flags_q.src_inc),
        .next_o (src_next)
    );

    dma_cb_addr_step #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_dst_step (
        .addr_i (dst_q),
        .inc_i  (flags_q.dst_inc),
        .next_o (dst_next)
    );

    assign fetch_words = mem_rdata_i >> BSH;
    assign fetch_last  = (fidx_q == FI_W'(CB_WORDS - 1));
    assign copy_last   = (left_q == DATA_W'(1));
    assign copying     = (state_q == ST_READ) || (state_q == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fidx_q  <= '0;
            cb_q    <= '0;
            flags_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            left_q  <= '0;
            buf_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_FETCH;
                        fidx_q  <= '0;
                        cb_q    <= cb_base_i;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready_i) begin
                        case (fidx_q)
                            FI_W'(0): flags_q <= decode_flags(32'(mem_rdata_i));
                            FI_W'(1): src_q   <= ADDR_W'(mem_rdata_i);
                            FI_W'(2): dst_q   <= ADDR_W'(mem_rdata_i);
                            default:  left_q  <= fetch_words;
                        endcase
                        fidx_q <= fidx_q + FI_W'(1);
                        if (fetch_last) begin
                            state_q <= (fetch_words == '0) ? ST_IDLE : ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready_i) begin
                        buf_q   <= mem_rdata_i;
                        state_q <= ST_WRITE;
                    end
                end
                default: begin
                    if (mem_ready_i) begin
                        src_q   <= src_next;
                        dst_q   <= dst_next;
                        left_q  <= left_q - DATA_W'(1);
                        state_q <= copy_last ? ST_IDLE : ST_READ;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_FETCH: mem_addr_o = cb_q + (ADDR_W'(fidx_q) << BSH);
            ST_READ:  mem_addr_o = src_q;
            ST_WRITE: mem_addr_o = dst_q;
            default:  mem_addr_o = '0;
        endcase
    end

    assign mem_req_o   = (state_q != ST_IDLE);
    assign mem_we_o    = (state_q == ST_WRITE);
    assign mem_wdata_o = buf_q;
    assign busy_o      = (state_q != ST_IDLE);

    assign done_o = mem_ready_i &&
                    (((state_q == ST_FETCH) && fetch_last && (fetch_words == '0)) ||
                     ((state_q == ST_WRITE) && copy_last));
    assign done_irq_o = done_o && flags_q.int_en;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                         && $stable(mem_we_o) && $stable(mem_wdata_o))); // R7

    AST_FIXED_SRC: assert property (@(posedge clk) disable iff (rst)
        (copying && !flags_q.src_inc) |=> $stable(src_q)); // R6

    AST_LAST_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && mem_ready_i && copy_last) |=> !mem_req_o); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (copying && start_i) |=> (state_q != ST_FETCH)); // R11

endmodule

// File: rtl/dma_cb_channel.sv
module dma_cb_channel
    import dma_cb_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);
    logic              start;
    logic              busy;
    logic              done;
    logic              done_irq;
    logic [ADDR_W-1:0] cb_base;

    dma_cb_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wen_i   (reg_wen),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .busy_i      (busy),
        .done_irq_i  (done_irq),
        .start_o     (start),
        .cb_base_o   (cb_base),
        .irq_o       (irq)
    );

    dma_cb_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cb_base_i   (cb_base),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy),
        .done_o      (done),
        .done_irq_o  (done_irq)
    );

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R8

endmodule

// File: tb/tb_dma_cb_channel.sv
`timescale 1ns/1ps
module tb_dma_cb_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dma_cb_channel dut (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: 256 words, ready from an LFSR
    logic [31:0] mem [0:255];
    logic [7:0]  lfsr = 8'h5B;
    int          wcount = 0;
    int          rcount = 0;
    logic [31:0] rlog [0:1023];
    int          hold_err = 0;
    logic        p_pend = 1'b0;
    logic [31:0] p_addr, p_wdata;
    logic        p_we;

    assign mem_ready = lfsr[0] | lfsr[1];
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (p_pend && !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
            hold_err <= hold_err + 1;
        p_pend  <= mem_req && !mem_ready;
        p_addr  <= mem_addr;
        p_we    <= mem_we;
        p_wdata <= mem_wdata;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wcount <= wcount + 1;
            end else begin
                rlog[rcount[9:0]] <= mem_addr;
                rcount <= rcount + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    localparam logic [31:0] CB_A  = 32'h300;
    localparam logic [31:0] SRC_A = 32'h040;
    localparam logic [31:0] DST_A = 32'h100;

    function automatic logic [31:0] src_val(input int run, input int i);
        return 32'h5A000000 | (run << 8) | i;
    endfunction

    function automatic logic [31:0] pre_val(input int run, input int k);
        return 32'hC0DE0000 | (run << 8) | k;
    endfunction

    // expected destination word k
    function automatic logic [31:0] exp_dst(input int run, input int n, input bit si,
                                            input bit di, input int k);
        if (di) begin
            if (k < n) return src_val(run, si ? k : 0);
            return pre_val(run, k);
        end
        if (k == 0 && n > 0) return src_val(run, si ? n - 1 : 0);
        return pre_val(run, k);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          run;
        int          lens [4];
        lens = '{0, 4, 12, 32};
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        reg_read(8'h00, rd); check("R1 cs", rd, 32'h0);
        reg_read(8'h04, rd); check("R1 cba", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 req", {31'b0, mem_req}, 32'h0);

        run = 0;
        for (int li = 0; li < 4; li++) begin
            for (int fl = 0; fl < 8; fl++) begin
                automatic bit ien = fl[0];
                automatic bit di  = fl[1];
                automatic bit si  = fl[2];
                automatic int n   = lens[li] / 4;
                automatic int wb, rb;
                automatic bit inj = 0;
                automatic bit done = 0;
                for (int i = 0; i < 8; i++) mem[SRC_A[9:2] + i] = src_val(run, i);
                for (int k = 0; k < 10; k++) mem[DST_A[9:2] + k] = pre_val(run, k);
                mem[CB_A[9:2] + 0] = (32'(si) << 8) | (32'(di) << 4) | 32'(ien);
                mem[CB_A[9:2] + 1] = SRC_A;
                mem[CB_A[9:2] + 2] = DST_A;
                mem[CB_A[9:2] + 3] = lens[li];
                reg_write(8'h04, CB_A);
                reg_read(8'h04, rd); check("R2 cba readback", rd, CB_A);
                wb = wcount; rb = rcount;
                reg_write(8'h00, 32'h1);
                reg_read(8'h00, rd); check("R8 active after start", rd & 32'h1, 32'h1);
                for (int cyc = 0; cyc < 2000; cyc++) begin
                    @(negedge clk);
                    reg_wen = 1'b0;
                    reg_read(8'h00, rd);
                    if (!rd[0]) begin done = 1; break; end
                    // R11: second start during the copy
                    if (!inj && n >= 2 && (wcount - wb) >= 1) begin
                        inj = 1;
                        reg_wdata = 32'h1; reg_wen = 1'b1;
                    end
                end
                reg_wen = 1'b0;
                check("R8 completes", {31'b0, done}, 32'h1);
                for (int k = 0; k < 4; k++)
                    check("R3 descriptor order", rlog[rb + k], CB_A + 32'(4 * k));
                check(n >= 2 ? "R11 write count" : "R4 write count",
                      32'(wcount - wb), 32'(n));
                check("R4 read count", 32'(rcount - rb), 32'(4 + n));
                for (int k = 0; k < 10; k++)
                    check(di ? "R5 dest word" : "R6 dest word",
                          mem[DST_A[9:2] + k], exp_dst(run, n, si, di, k));
                check("R9 irq", {31'b0, irq}, {31'b0, ien});
                reg_read(8'h00, rd); check("R9 cs int", rd, ien ? 32'h4 : 32'h0);
                reg_write(8'h00, 32'h4);
                reg_read(8'h00, rd); check("R10 cs cleared", rd, 32'h0);
                check("R10 irq low", {31'b0, irq}, 32'h0);
                run++;
            end
        end
        check("R7 request hold", 32'(hold_err), 32'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule